// File: doc/BRIEF.md
# Compare-Match Toggle Output Channel

This block is a single compare channel that watches a shared, free-running 16-bit timebase. Software loads a 16-bit compare value through two byte-wide register writes. Once the channel is armed, the output pin flips its level each time the timebase reaches that value. The same event also sets a sticky flag, and that flag can drive an interrupt request.

The compare value is loaded in two writes. Writing the low byte disarms the compare path. Writing the high byte arms it again. A two-byte update done low byte first therefore cannot match against a half-written value. The flag is cleared only by software. If a clear and a new match land in the same cycle, the match wins.

All pins are plain control and status signals. There is no streamed data, so there is no valid/ready handshake. A register write takes effect on the clock edge that samples `reg_wr`. Read data is combinational on `reg_addr`.

Top module: `cmt_channel`

## Requirements
- R1: After reset, `tgl_out`, the flag and `irq` are 0, and every register reads back as 0.
- R2: The register map is as follows. Address 0 is control: bit0 interrupt enable, bit1 compare enable, bit2 match enable, bit3 toggle enable. Address 1 is the compare low byte. Address 2 is the compare high byte. Address 3 is status, with the flag in bit0. All four read back what they hold, and unused bits read as 0.
- R3: When toggle enable, match enable and compare enable are all 1, a match inverts `tgl_out` on the clock edge where the timebase first equals the compare value.
- R4: A match is the first cycle of equality only. While the timebase stays at the compare value, `tgl_out` does not invert again. It inverts again only after the equality has gone away and then returned.
- R5: A match with compare enable and match enable both set makes the flag 1. The flag then stays 1 until software clears it.
- R6: `irq` is 1 exactly when the flag is 1 and interrupt enable is 1.
- R7: Writing status with bit0 = 0 clears the flag. Writing status with bit0 = 1 has no effect.
- R8: If a status clear and a match fall in the same cycle, the flag ends up 1.
- R9: A write to the compare low byte clears compare enable. No match is seen after that until the high byte is written.
- R10: A write to the compare high byte sets compare enable.
- R11: With compare enable at 0, `tgl_out` holds its level on a timebase match. With toggle enable at 0, `tgl_out` also holds its level, but the flag still sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_wr | input | 1 | Write strobe |
| reg_rdata | output | 8 | Register read data (combinational) |
| timebase | input | 16 | Shared free-running count |
| tgl_out | output | 1 | Toggle output pin |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can fall in the same cycle: a software clear of the flag and a hardware match that sets it. The bench provokes the collision by driving the status write (bit0 = 0) and the matching timebase value on the same falling edge. After the next edge it expects the flag to read 1, and then confirms that a clear on its own does remove it. A second same-cycle case is a low-byte write that lands while the timebase equals the old compare value. That case is covered by the rule that the low-byte write leaves the channel disarmed afterwards.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    CMT_A_CTRL  = 2'd0,
    CMT_A_CMPLO = 2'd1,
    CMT_A_CMPHI = 2'd2,
    CMT_A_STAT  = 2'd3
  } cmt_addr_e;

  // bit3 toggle, bit2 match, bit1 compare, bit0 interrupt
  typedef struct packed {
    logic tgl_en;
    logic mat_en;
    logic cmp_en;
    logic irq_en;
  } cmt_ctrl_t;

  localparam int CTRL_W = $bits(cmt_ctrl_t);
endpackage

// File: rtl/cmt_regbank.sv
module cmt_regbank
  import cmt_pkg::*;
#(
  parameter int DW = 8,
  localparam int CW = 2 * DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  input  logic              wr,
  input  logic              flag,
  output logic [DW-1:0]     rdata,
  output cmt_ctrl_t         ctrl,
  output logic [CW-1:0]     cmp,
  output logic              clr_req
);
  logic [DW-1:0] cmp_lo_q, cmp_hi_q;
  cmt_ctrl_t     ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      cmp_lo_q <= '0;
      cmp_hi_q <= '0;
    end else if (wr) begin
      unique case (cmt_addr_e'(addr))
        CMT_A_CTRL:  ctrl_q <= cmt_ctrl_t'(wdata[CTRL_W-1:0]);
        CMT_A_CMPLO: begin
          cmp_lo_q      <= wdata;
          ctrl_q.cmp_en <= 1'b0;
        end
        CMT_A_CMPHI: begin
          cmp_hi_q      <= wdata;
          ctrl_q.cmp_en <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign ctrl    = ctrl_q;
  assign cmp     = {cmp_hi_q, cmp_lo_q};
  assign clr_req = wr && (cmt_addr_e'(addr) == CMT_A_STAT) && !wdata[0];

  always_comb begin
    unique case (cmt_addr_e'(addr))
      CMT_A_CTRL:  rdata = {{(DW-CTRL_W){1'b0}}, ctrl_q};
      CMT_A_CMPLO: rdata = cmp_lo_q;
      CMT_A_CMPHI: rdata = cmp_hi_q;
      default:     rdata = {{(DW-1){1'b0}}, flag};
    endcase
  end

  AST_LOW_WRITE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && cmt_addr_e'(addr) == CMT_A_CMPLO) |=> !ctrl.cmp_en); // R9
  AST_HIGH_WRITE_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && cmt_addr_e'(addr) == CMT_A_CMPHI) |=> ctrl.cmp_en); // R10
endmodule

// File: rtl/cmt_match.sv
module cmt_match #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] timebase,
  input  logic [CW-1:0] cmp,
  input  logic          arm,
  output logic          match_evt
);
  logic eq, eq_q;

  assign eq = (timebase == cmp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eq_q <= 1'b0;
    else        eq_q <= eq;
  end

  // only the first cycle of equality counts
  assign match_evt = eq && !eq_q && arm;

  AST_ONE_EVENT_PER_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> !match_evt); // R4
endmodule

// File: rtl/cmt_outstage.sv
module cmt_outstage (
  input  logic clk,
  input  logic rst_n,
  input  logic match_evt,
  input  logic tgl_ok,
  input  logic clr_req,
  output logic pin,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin  <= 1'b0;
      flag <= 1'b0;
    end else begin
      if (match_evt && tgl_ok) pin <= !pin;
      if (match_evt)           flag <= 1'b1;
      else if (clr_req)        flag <= 1'b0;
    end
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr_req) |=> flag); // R5
  AST_MATCH_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && clr_req) |=> flag); // R8
endmodule

// File: rtl/cmt_channel.sv
module cmt_channel
  import cmt_pkg::*;
#(
  parameter int DW = 8,
  localparam int CW = 2 * DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  input  logic              reg_wr,
  output logic [DW-1:0]     reg_rdata,
  input  logic [CW-1:0]     timebase,
  output logic              tgl_out,
  output logic              irq
);
  cmt_ctrl_t     ctrl;
  logic [CW-1:0] cmp;
  logic          clr_req, flag, match_evt, arm, tgl_ok;

  cmt_regbank #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wdata(reg_wdata), .wr(reg_wr),
    .flag(flag), .rdata(reg_rdata), .ctrl(ctrl), .cmp(cmp), .clr_req(clr_req)
  );

  assign arm    = ctrl.cmp_en && ctrl.mat_en;
  assign tgl_ok = ctrl.tgl_en;

  cmt_match #(.CW(CW)) u_match (
    .clk(clk), .rst_n(rst_n), .timebase(timebase), .cmp(cmp), .arm(arm),
    .match_evt(match_evt)
  );

  cmt_outstage u_out (
    .clk(clk), .rst_n(rst_n), .match_evt(match_evt), .tgl_ok(tgl_ok),
    .clr_req(clr_req), .pin(tgl_out), .flag(flag)
  );

  assign irq = flag && ctrl.irq_en;

  AST_PIN_HOLDS_DISARMED: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.cmp_en |=> $stable(tgl_out)); // R11
  AST_PIN_HOLDS_NO_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.tgl_en |=> $stable(tgl_out)); // R11
endmodule

// File: tb/cmt_channel_test.sv
module cmt_channel_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_rdata;
  logic [15:0] timebase = '0;
  logic        tgl_out, irq;

  int checks = 0;
  int fails = 0;

  always #4 clk = !clk;

  cmt_channel uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rdata(reg_rdata), .timebase(timebase),
    .tgl_out(tgl_out), .irq(irq)
  );

  // {timebase, expected pin, expected flag}; compare = 0x1234, all enables on
  localparam logic [17:0] VEC [8] = '{
    {16'h1233, 1'b0, 1'b0},
    {16'h1234, 1'b1, 1'b1},
    {16'h1234, 1'b1, 1'b1},
    {16'h1235, 1'b1, 1'b1},
    {16'h1234, 1'b0, 1'b1},
    {16'h0000, 1'b0, 1'b1},
    {16'h1234, 1'b1, 1'b1},
    {16'hFFFF, 1'b1, 1'b1}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic set_tb(input logic [15:0] v);
    @(negedge clk);
    timebase = v;
    @(negedge clk);
  endtask

  task automatic flag_rd(output logic f);
    logic [7:0] d;
    rd_reg(2'd3, d);
    f = d[0];
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    logic f;
    logic pin_before;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, R2 map reads 0
    chk("R1 pin", tgl_out, 0);
    chk("R1 irq", irq, 0);
    for (int a = 0; a < 4; a++) begin
      rd_reg(a[1:0], d);
      chk("R1 R2 reg reset", d, 0);
    end

    wr_reg(2'd0, 8'h0F);
    wr_reg(2'd1, 8'h34);
    wr_reg(2'd2, 8'h12);
    rd_reg(2'd0, d); chk("R2 ctrl", d, 8'h0F);
    rd_reg(2'd1, d); chk("R2 low", d, 8'h34);
    rd_reg(2'd2, d); chk("R2 high", d, 8'h12);

    // vector walk: R3 toggle, R4 one per value, R5 sticky flag, R6 irq
    for (int i = 0; i < 8; i++) begin
      set_tb(VEC[i][17:2]);
      chk("R3 R4 pin", tgl_out, VEC[i][1]);
      flag_rd(f);
      chk("R5 flag", f, VEC[i][0]);
      chk("R6 irq", irq, VEC[i][0]);
    end

    // R7 clear and write-1 no effect
    wr_reg(2'd3, 8'h00);
    flag_rd(f); chk("R7 clear", f, 0);
    chk("R7 irq after clear", irq, 0);
    wr_reg(2'd3, 8'h01);
    flag_rd(f); chk("R7 write one ignored", f, 0);

    // R9 low write disarms
    wr_reg(2'd1, 8'h00);
    rd_reg(2'd0, d); chk("R9 ctrl after low", d, 8'h0D);
    set_tb(16'h1200);
    chk("R9 pin held", tgl_out, 1);
    flag_rd(f); chk("R9 no flag", f, 0);

    // R10 high write rearms
    set_tb(16'h0001);
    wr_reg(2'd2, 8'h12);
    rd_reg(2'd0, d); chk("R10 ctrl after high", d, 8'h0F);
    set_tb(16'h1200);
    chk("R10 R3 pin toggles", tgl_out, 0);
    flag_rd(f); chk("R10 flag", f, 1);

    // R8 clear and match in the same cycle
    wr_reg(2'd3, 8'h00);
    set_tb(16'h0002);
    @(negedge clk);
    reg_addr = 2'd3; reg_wdata = 8'h00; reg_wr = 1'b1;
    timebase = 16'h1200;
    @(negedge clk);
    reg_wr = 1'b0;
    flag_rd(f); chk("R8 match wins", f, 1);
    chk("R8 pin", tgl_out, 1);
    wr_reg(2'd3, 8'h00);
    flag_rd(f); chk("R8 lone clear", f, 0);

    // R11 toggle disabled: flag sets, pin holds
    wr_reg(2'd0, 8'h07);
    set_tb(16'h0003);
    pin_before = tgl_out;
    set_tb(16'h1200);
    chk("R11 pin held no toggle", tgl_out, pin_before);
    flag_rd(f); chk("R11 flag still sets", f, 1);

    // R6 irq masked
    wr_reg(2'd0, 8'h06);
    chk("R6 irq masked", irq, 0);
    wr_reg(2'd0, 8'h07);
    chk("R6 irq unmasked", irq, 1);

    // R11 compare disabled: pin holds, no flag
    wr_reg(2'd3, 8'h00);
    wr_reg(2'd0, 8'h0D);
    set_tb(16'h0004);
    pin_before = tgl_out;
    set_tb(16'h1200);
    chk("R11 pin held disarmed", tgl_out, pin_before);
    flag_rd(f); chk("R11 no flag disarmed", f, 0);

    finish_run();
  end
endmodule